// File: doc/BRIEF.md
# Four-Phase Non-Overlapping Clock Generator

This block turns one fast reference clock into four logic-level clock phases for circuits that need a multi-phase, non-overlapping clock. One shared position counter sets the output period. Each phase is high once per period, for a run-time width, and the phases fire in the fixed order 0, 1, 2, 3. A run-time gap keeps each phase apart from the next. Because every phase is decoded from the same counter, the four phases cannot drift apart.

The period, width and gap come from three configuration inputs. The block copies them into its working registers only while it is stopped, in reset, or at the end of a period, so a running pulse is never cut short or stretched. A setting that cannot fit four separated pulses into one period is refused: all phases stay low and an error flag is raised. An enable input starts all four phases together from position 0 and stops them. A synchronous reset does the same. Every output pin is driven directly by a flip-flop.

Top module: `quad_phase_clkgen`

## Requirements
- R1: At no clock edge is more than one bit of `phaseOut` high.
- R2: Let P, W and G be the working period, width and gap. The first rising edge with `enable` sampled high shows position 0, and each later edge shows the next position modulo P. At position n, bit k of `phaseOut` is high exactly when k*(W+G) <= n <= k*(W+G)+W-1.
- R3: With P=16, W=3 and G=1, the phases are high at positions 0-2, 4-6, 8-10 and 12-14, and the pattern repeats every 16 cycles.
- R4: With P=12, W=2 and G=1, the phases are high at positions 0-1, 3-4, 6-7 and 9-10, and the pattern repeats every 12 cycles.
- R5: A setting is valid only when W >= 1, G >= 1 and P >= 4*(W+G). A setting that is loaded and invalid sets `cfgError` to 1 and keeps `phaseOut` at 0. Once a valid setting is loaded again, `cfgError` returns to 0 at the edge that loads it, and position 0 appears at the edge after that.
- R6: Changes to the configuration inputs while running take effect only at the edge that follows position P-1. Until then, the current period completes under the old setting.
- R7: While `enable` is low, `phaseOut` is 0 from the next edge on, and the inputs are loaded at every edge. Raising `enable` restarts the outputs at position 0.
- R8: While `rst` is high, each edge clears `phaseOut` and the position counter, and loads the configuration inputs. The edge after `rst` falls, with `enable` high, shows position 0.
- R9: After a phase falls, the next phase in the rotation (3 is followed by 0) is still low on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Runs the phases when high; holds them low and restarts the count when low |
| cfgPeriod | input | CNT_W | Period in reference cycles |
| cfgWidth | input | CNT_W | High time of each phase in reference cycles |
| cfgGap | input | CNT_W | Low cycles between one phase falling and the next rising |
| phaseOut | output | 4 | Phase outputs, bit k is phase k |
| cfgError | output | 1 | High while the loaded setting is invalid |

## Verification
The bench builds the block with `CNT_W` set to 6. That makes every width from 1 to 3, gaps of 1 and 2, and periods from the tightest valid value to two cycles above it small enough to sweep completely. Each of these settings runs for two full periods, and every position is compared against the window formula. Directed runs cover a mid-period change of setting, each class of invalid setting, recovery from an invalid setting while enabled, and disable and reset in the middle of a period.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic clear;   // force the position counter to zero
    logic load;    // copy the configuration inputs into the working registers
    logic run;     // allow the phase registers to follow the decoded windows
  } qpcStrobes_t;

endpackage

// File: rtl/qpc_phase_slot.sv
module qpc_phase_slot #(
  parameter int CNT_W = 8,
  parameter int EXT_W = CNT_W + 3,
  parameter int IDX   = 0
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] width,
  input  logic [CNT_W-1:0] gap,
  output logic             hit
);

  logic [EXT_W-1:0] stride;
  logic [EXT_W-1:0] startPos;
  logic [EXT_W-1:0] endPos;
  logic [EXT_W-1:0] cntExt;

  always_comb begin
    stride   = EXT_W'(width) + EXT_W'(gap);
    startPos = stride * EXT_W'(IDX);
    endPos   = startPos + EXT_W'(width);
    cntExt   = EXT_W'(cnt);
    hit      = (cntExt >= startPos) && (cntExt < endPos);
  end

endmodule

// File: rtl/qpc_ctrl.sv
module qpc_ctrl
  import qpc_pkg::*;
(
  input  logic        rst,
  input  logic        enable,
  input  logic        cntAtEnd,
  input  logic        actValid,
  output qpcStrobes_t strb
);

  always_comb begin
    strb.clear = rst || !enable;
    // An invalid working setting is reloaded every cycle so a fix lands at once
    strb.load  = rst || !enable || !actValid || cntAtEnd;
    strb.run   = !rst && enable && actValid;
  end

endmodule

// File: rtl/qpc_datapath.sv
module qpc_datapath
  import qpc_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int NPH   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  qpcStrobes_t      strb,
  input  logic [CNT_W-1:0] cfgPeriod,
  input  logic [CNT_W-1:0] cfgWidth,
  input  logic [CNT_W-1:0] cfgGap,
  output logic             cntAtEnd,
  output logic             actValid,
  output logic [NPH-1:0]   phaseOut,
  output logic             cfgError
);

  localparam int EXT_W = CNT_W + $clog2(NPH) + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] actPeriod;
  logic [CNT_W-1:0] actWidth;
  logic [CNT_W-1:0] actGap;
  logic             actValidQ;
  logic [NPH-1:0]   phaseQ;
  logic [NPH-1:0]   slotHit;
  logic [EXT_W-1:0] needLen;
  logic             inValid;

  // Check the incoming setting before it is loaded
  always_comb begin
    needLen = (EXT_W'(cfgWidth) + EXT_W'(cfgGap)) * EXT_W'(NPH);
    inValid = (cfgWidth != '0) && (cfgGap != '0) &&
              (EXT_W'(cfgPeriod) >= needLen);
  end

  always_ff @(posedge clk) begin
    if (strb.load) begin
      actPeriod <= cfgPeriod;
      actWidth  <= cfgWidth;
      actGap    <= cfgGap;
      actValidQ <= inValid;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.clear || strb.load) cnt <= '0;
    else                         cnt <= cnt + 1'b1;
  end

  assign cntAtEnd = (cnt == actPeriod - 1'b1);

  genvar k;
  generate
    for (k = 0; k < NPH; k++) begin : g_slot
      qpc_phase_slot #(
        .CNT_W(CNT_W),
        .EXT_W(EXT_W),
        .IDX  (k)
      ) u_slot (
        .cnt  (cnt),
        .width(actWidth),
        .gap  (actGap),
        .hit  (slotHit[k])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strb.run) phaseQ <= slotHit;
    else          phaseQ <= '0;
  end

  assign phaseOut = phaseQ;
  assign actValid = actValidQ;
  assign cfgError = !actValidQ;

  // R1: at most one phase is high
  p_no_overlap_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(phaseQ));

  // R2: the counter stays inside a valid period
  p_cnt_in_period_r2: assert property (@(posedge clk) disable iff (rst)
    actValidQ |-> (cnt < actPeriod));

  // R5: an invalid setting keeps every phase low
  p_error_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !actValidQ |-> (phaseQ == '0));

  // R6: the working setting only changes when the counter restarts
  p_cfg_held_r6: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |-> ($stable(actPeriod) && $stable(actWidth) && $stable(actGap)));

  // R9: the next phase is still low on the edge where a phase falls
  generate
    for (k = 0; k < NPH; k++) begin : g_gapchk
      p_dead_gap_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(phaseQ[k]) |-> !phaseQ[(k + 1) % NPH]);
    end
  endgenerate

endmodule

// File: rtl/quad_phase_clkgen.sv
module quad_phase_clkgen
  import qpc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [CNT_W-1:0] cfgPeriod,
  input  logic [CNT_W-1:0] cfgWidth,
  input  logic [CNT_W-1:0] cfgGap,
  output logic [3:0]       phaseOut,
  output logic             cfgError
);

  localparam int NPH = 4;

  qpcStrobes_t strb;
  logic        cntAtEnd;
  logic        actValid;

  qpc_ctrl u_ctrl (
    .rst     (rst),
    .enable  (enable),
    .cntAtEnd(cntAtEnd),
    .actValid(actValid),
    .strb    (strb)
  );

  qpc_datapath #(
    .CNT_W(CNT_W),
    .NPH  (NPH)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .cfgPeriod(cfgPeriod),
    .cfgWidth (cfgWidth),
    .cfgGap   (cfgGap),
    .cntAtEnd (cntAtEnd),
    .actValid (actValid),
    .phaseOut (phaseOut),
    .cfgError (cfgError)
  );

  // R7: a low enable silences all phases on the next edge
  p_disable_low_r7: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (phaseOut == '0));

endmodule

// File: tb/quad_phase_clkgen_tb.sv
`timescale 1ns/1ps
module quad_phase_clkgen_tb;

  localparam int CNT_W = 6;

  logic             clk = 1'b0;
  logic             rst;
  logic             enable;
  logic [CNT_W-1:0] cfgPeriod;
  logic [CNT_W-1:0] cfgWidth;
  logic [CNT_W-1:0] cfgGap;
  logic [3:0]       phaseOut;
  logic             cfgError;

  int checks = 0;
  int errors = 0;
  logic [3:0] prevPh;

  always #2.5 clk = ~clk;

  quad_phase_clkgen #(.CNT_W(CNT_W)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .cfgPeriod(cfgPeriod),
    .cfgWidth (cfgWidth),
    .cfgGap   (cfgGap),
    .phaseOut (phaseOut),
    .cfgError (cfgError)
  );

  function automatic logic [3:0] expWin(int pos, int w, int g);
    logic [3:0] r = '0;
    for (int k = 0; k < 4; k++)
      if (pos >= k * (w + g) && pos < k * (w + g) + w) r[k] = 1'b1;
    return r;
  endfunction

  task automatic chkVal(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chkErr(string req, logic exp);
    checks++;
    if (cfgError !== exp) begin
      errors++;
      $display("FAIL %s cfgError: actual=%b expected=%b at %0t", req, cfgError, exp, $time);
    end
  endtask

  // Checks made on every sample of a running pattern
  task automatic sampleRun(string req, int pos, int w, int g);
    chkVal(req, phaseOut, expWin(pos, w, g));
    checks++;
    if ($countones(phaseOut) > 1) begin
      errors++;
      $display("FAIL R1: actual=%b expected=at most one bit high", phaseOut);
    end
    for (int k = 0; k < 4; k++)
      if (prevPh[k] && !phaseOut[k]) begin
        checks++;
        if (phaseOut[(k + 1) % 4] !== 1'b0) begin
          errors++;
          $display("FAIL R9: actual=%b expected next phase low", phaseOut);
        end
      end
    prevPh = phaseOut;
  endtask

  // Load a setting while stopped, then run n positions from position 0
  task automatic runCfg(string req, int p, int w, int g, int n);
    @(negedge clk);
    enable = 1'b0;
    cfgPeriod = CNT_W'(p); cfgWidth = CNT_W'(w); cfgGap = CNT_W'(g);
    @(negedge clk);
    @(negedge clk);
    chkErr("R5", 1'b0);
    enable = 1'b1;
    prevPh = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sampleRun(req, i % p, w, g);
    end
  endtask

  task automatic badCfg(int p, int w, int g);
    @(negedge clk);
    enable = 1'b0;
    cfgPeriod = CNT_W'(p); cfgWidth = CNT_W'(w); cfgGap = CNT_W'(g);
    @(negedge clk);
    @(negedge clk);
    chkErr("R5", 1'b1);
    enable = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chkVal("R5", phaseOut, 4'b0000);
      chkErr("R5", 1'b1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; enable = 1'b0;
    cfgPeriod = 6'd16; cfgWidth = 6'd3; cfgGap = 6'd1;
    repeat (3) @(negedge clk);
    chkVal("R8", phaseOut, 4'b0000);
    chkErr("R8", 1'b0);
    rst = 1'b0;

    runCfg("R3", 16, 3, 1, 48);
    runCfg("R4", 12, 2, 1, 36);

    // R2 sweep over small settings
    for (int w = 1; w <= 3; w++)
      for (int g = 1; g <= 2; g++)
        for (int x = 0; x <= 2; x++)
          runCfg("R2", 4 * (w + g) + x, w, g, 2 * (4 * (w + g) + x));

    // R6: change of setting in the middle of a period
    runCfg("R6", 16, 3, 1, 5);
    cfgPeriod = 6'd12; cfgWidth = 6'd2; cfgGap = 6'd1;
    for (int i = 5; i < 16; i++) begin
      @(negedge clk);
      sampleRun("R6", i, 3, 1);
    end
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      sampleRun("R6", i % 12, 2, 1);
    end

    // R5: every class of invalid setting, then recovery while enabled
    badCfg(15, 3, 1);
    badCfg(16, 0, 1);
    badCfg(16, 3, 0);
    cfgPeriod = 6'd16; cfgWidth = 6'd3; cfgGap = 6'd1;
    @(negedge clk);
    chkVal("R5", phaseOut, 4'b0000);
    chkErr("R5", 1'b0);
    prevPh = '0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      sampleRun("R5", i, 3, 1);
    end

    // R7: disable in the middle of a period and restart
    runCfg("R7", 16, 3, 1, 10);
    enable = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chkVal("R7", phaseOut, 4'b0000);
    end
    enable = 1'b1;
    prevPh = '0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      sampleRun("R7", i, 3, 1);
    end

    // R8: reset in the middle of a period
    runCfg("R8", 12, 2, 1, 7);
    rst = 1'b1;
    @(negedge clk);
    chkVal("R8", phaseOut, 4'b0000);
    chkErr("R8", 1'b0);
    cfgPeriod = 6'd15; cfgWidth = 6'd3; cfgGap = 6'd1;
    @(negedge clk);
    chkErr("R8", 1'b1);
    cfgPeriod = 6'd16;
    @(negedge clk);
    chkErr("R8", 1'b0);
    rst = 1'b0;
    prevPh = '0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      sampleRun("R8", i, 3, 1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule